// File: doc/BRIEF.md
# Dual-Channel Digitizer Sample Aligner and Framer

This block sits between two pipelined floating-point charge digitizers and a serializer. Every clock of the 40 MHz bunch rate it takes one sample from each channel: a 2-bit exponent, a 5-bit mantissa and a 2-bit time-slice identifier. The time-slice identifier cycles through four values because each digitizer rotates through a four-stage pipeline. Each channel has its own alignment delay of zero to three clocks. After alignment the block compares the two time-slice identifiers, and any disagreement sets a sticky synchronization-error flag. The block then emits one 16-bit word per clock, and a 2-bit type field at the top of that word tells the receiver what the word carries.

A pulse on the orbit-start marker replaces that cycle's output with an orbit word. The orbit word carries the length of the previous orbit, taken from a 12-bit bunch counter. In the same cycle the block drives a one-cycle reset to both digitizers, so that their time-slice identifiers restart at zero. A test mode replaces the sample words with the contents of twenty byte-wide pattern registers, sent in a rotation. Each test word carries its register index, which lets the receiving end check the acquisition path and the cable mapping. Configuration is written through a small write-only port.

Top module: `dual_digitizer_framer`

## Requirements
- R1: While reset is held, frame_word, dig_rst and sync_err are all zero.
- R2: With both delays zero, a cycle without the orbit marker and outside test mode outputs {2'b01, exp1, mant1, exp0, mant0}. The layout is: bits 15:14 type, 13:12 exp1, 11:7 mant1, 6:5 exp0, 4:0 mant0. The word appears after the clock edge that samples the inputs.
- R3: Control register (address 0) bits [1:0] set the delay of channel 0 and bits [3:2] set the delay of channel 1. A delay of d clocks makes that channel's sample appear in the word d clocks later than with delay 0. Samples held in the delay line before reset are zero.
- R4: A bc0 pulse sampled at an edge makes the next word {2'b10, 2'b00, count}. Here count is the number of edges since the previous bc0 (or since reset) minus one, saturating at 4095. The counter then restarts at zero.
- R5: dig_rst is high for exactly the cycle that follows each edge that samples bc0.
- R6: sync_err rises after any edge at which the aligned time-slice identifiers of the two channels differ, and stays high afterwards.
- R7: Writing address 0 with bit 5 set clears sync_err at that edge, unless a mismatch occurs at the same edge, in which case the flag stays set.
- R8: Control bit 4 enables test mode. In test mode each non-orbit word is {2'b11, idx[4:0], 1'b0, pattern[idx][7:0]}. Pattern registers sit at addresses 1 to 20 and hold indices 0 to 19. idx advances after each test word, wraps from 19 to 0, and returns to 0 on bc0.
- R9: The orbit word takes precedence over both test and sample words. The samples present in the bc0 cycle are not transmitted.
- R10: Writes to addresses 21 to 31 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bc0 | input | 1 | Orbit-start marker, one cycle |
| ch0_exp | input | 2 | Channel 0 exponent |
| ch0_mant | input | 5 | Channel 0 mantissa |
| ch0_cap | input | 2 | Channel 0 time-slice identifier |
| ch1_exp | input | 2 | Channel 1 exponent |
| ch1_mant | input | 5 | Channel 1 mantissa |
| ch1_cap | input | 2 | Channel 1 time-slice identifier |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| frame_word | output | 16 | Typed word toward the serializer |
| dig_rst | output | 1 | Reset pulse to both digitizers |
| sync_err | output | 1 | Sticky time-slice mismatch flag |

## Verification
Sample words are tried with random exponents and mantissas under every pairing of channel delays, including unequal pairs. Unequal delays separate a wrong tap from a wrong channel ordering. The time-slice streams come from digitizer models that restart on dig_rst, with rare single-cycle glitches injected. This shows whether the mismatch check and its sticky clear act on the aligned samples rather than the raw ones. Orbit gaps are random and are followed by one gap longer than 4095 cycles, which separates correct counting from wrap-around. Test-mode runs cross orbit boundaries and follow writes to unmapped addresses, which exposes index wrap, restart on the orbit marker and unwanted register updates.

// File: rtl/ddf_pkg.sv
package ddf_pkg;

   typedef enum logic [1:0] {
      WT_IDLE  = 2'b00,
      WT_DATA  = 2'b01,
      WT_ORBIT = 2'b10,
      WT_TEST  = 2'b11
   } word_type_e;

   localparam int unsigned CFG_BYTE_W = 8;

endpackage

// File: rtl/ddf_align_delay.sv
module ddf_align_delay #(
   parameter int unsigned W       = 9,
   parameter int unsigned MAX_DLY = 3,
   parameter int unsigned SEL_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic [W-1:0]     din,
   output logic [W-1:0]     dout
);

   initial begin
      if (W == 0) $fatal(1, "ddf_align_delay: W must be nonzero");
      if ((1 << SEL_W) < MAX_DLY + 1) $fatal(1, "ddf_align_delay: SEL_W too narrow");
   end

   generate
      if (MAX_DLY == 0) begin : g_passthru
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst_n, sel};
         assign dout = din;
      end else begin : g_taps
         logic [W-1:0] sh [MAX_DLY];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < MAX_DLY; i++) sh[i] <= '0;
            end else begin
               sh[0] <= din;
               for (int i = 1; i < MAX_DLY; i++) sh[i] <= sh[i-1];
            end
         end

         always_comb begin
            dout = din;
            for (int i = 1; i <= MAX_DLY; i++)
               if (sel == SEL_W'(i)) dout = sh[i-1];
         end

         if (MAX_DLY >= 2) begin : g_chk
            // R3: each stage holds what the previous stage held one clock earlier
            a_r3_shift_chain: assert property (@(posedge clk) disable iff (!rst_n)
               sh[1] == $past(sh[0]));
         end
      end
   endgenerate

endmodule

// File: rtl/ddf_cfg_regs.sv
module ddf_cfg_regs #(
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned NUM_PAT = 20,
   parameter int unsigned NUM_CH  = 2,
   parameter int unsigned DSEL_W  = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                we,
   input  logic [ADDR_W-1:0]                   addr,
   input  logic [ddf_pkg::CFG_BYTE_W-1:0]      wdata,
   output logic [NUM_CH-1:0][DSEL_W-1:0]       dly_sel,
   output logic                                test_en,
   output logic                                clr_err,
   output logic [NUM_PAT-1:0][ddf_pkg::CFG_BYTE_W-1:0] pat
);
   localparam int unsigned BW       = ddf_pkg::CFG_BYTE_W;
   localparam int unsigned TEST_BIT = NUM_CH * DSEL_W;
   localparam int unsigned CLR_BIT  = TEST_BIT + 1;

   initial begin
      if (CLR_BIT >= BW) $fatal(1, "ddf_cfg_regs: control fields exceed one byte");
      if ((1 << ADDR_W) < NUM_PAT + 1) $fatal(1, "ddf_cfg_regs: ADDR_W too narrow");
   end

   logic [TEST_BIT:0] ctrl_q;
   logic              ctrl_hit;

   assign ctrl_hit = we && (addr == '0);
   assign clr_err  = ctrl_hit && wdata[CLR_BIT];
   assign test_en  = ctrl_q[TEST_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n)        ctrl_q <= '0;
      else if (ctrl_hit) ctrl_q <= wdata[TEST_BIT:0];
   end

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
         assign dly_sel[c] = ctrl_q[c*DSEL_W +: DSEL_W];
      end
      for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
         always_ff @(posedge clk) begin
            if (!rst_n)                              pat[p] <= '0;
            else if (we && addr == ADDR_W'(p + 1))   pat[p] <= wdata;
         end
      end
   endgenerate

   // R10: unmapped addresses leave every pattern byte untouched
   a_r10_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr > ADDR_W'(NUM_PAT)) |=> pat == $past(pat));

   // R10: unmapped addresses leave the control fields untouched
   a_r10_ctrl_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr > ADDR_W'(NUM_PAT)) |=> $stable(ctrl_q));

endmodule

// File: rtl/ddf_orbit_ctrl.sv
module ddf_orbit_ctrl #(
   parameter int unsigned BX_W    = 12,
   parameter int unsigned NUM_PAT = 20,
   parameter int unsigned IDX_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bc0,
   input  logic             test_en,
   output logic [BX_W-1:0]  bx_cnt,
   output logic [IDX_W-1:0] tst_idx
);

   initial begin
      if (NUM_PAT < 2) $fatal(1, "ddf_orbit_ctrl: need at least two patterns");
      if ((1 << IDX_W) < NUM_PAT) $fatal(1, "ddf_orbit_ctrl: IDX_W too narrow");
   end

   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_PAT - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)           bx_cnt <= '0;
      else if (bc0)         bx_cnt <= '0;
      else if (bx_cnt != '1) bx_cnt <= bx_cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       tst_idx <= '0;
      else if (bc0)     tst_idx <= '0;
      else if (test_en) tst_idx <= (tst_idx == IDX_LAST) ? '0 : tst_idx + 1'b1;
   end

   // R4: the counter steps by one between orbit markers until it saturates
   a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!bc0 && bx_cnt != '1) |=> bx_cnt == $past(bx_cnt) + 1'b1);

   // R4: a saturated counter holds its value until the next marker
   a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (!bc0 && bx_cnt == '1) |=> bx_cnt == '1);

   // R8: the pattern index never leaves the register range
   a_r8_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      tst_idx <= IDX_LAST);

   // R8: the pattern index holds while test mode is off
   a_r8_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!bc0 && !test_en) |=> $stable(tst_idx));

endmodule

// File: rtl/dual_digitizer_framer.sv
module dual_digitizer_framer #(
   parameter int unsigned EXP_W   = 2,
   parameter int unsigned MANT_W  = 5,
   parameter int unsigned CAP_W   = 2,
   parameter int unsigned MAX_DLY = 3,
   parameter int unsigned NUM_PAT = 20,
   parameter int unsigned BX_W    = 12
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 bc0,
   input  logic [EXP_W-1:0]                     ch0_exp,
   input  logic [MANT_W-1:0]                    ch0_mant,
   input  logic [CAP_W-1:0]                     ch0_cap,
   input  logic [EXP_W-1:0]                     ch1_exp,
   input  logic [MANT_W-1:0]                    ch1_mant,
   input  logic [CAP_W-1:0]                     ch1_cap,
   input  logic                                 cfg_we,
   input  logic [$clog2(NUM_PAT+1)-1:0]         cfg_addr,
   input  logic [7:0]                           cfg_wdata,
   output logic [2+2*(EXP_W+MANT_W)-1:0]        frame_word,
   output logic                                 dig_rst,
   output logic                                 sync_err
);
   import ddf_pkg::*;

   localparam int unsigned NUM_CH = 2;
   localparam int unsigned SMP_W  = EXP_W + MANT_W;
   localparam int unsigned DW     = CAP_W + SMP_W;
   localparam int unsigned PAY_W  = NUM_CH * SMP_W;
   localparam int unsigned WORD_W = 2 + PAY_W;
   localparam int unsigned DSEL_W = (MAX_DLY > 0) ? $clog2(MAX_DLY + 1) : 1;
   localparam int unsigned ADDR_W = $clog2(NUM_PAT + 1);
   localparam int unsigned IDX_W  = $clog2(NUM_PAT);
   localparam int unsigned BW     = CFG_BYTE_W;

   initial begin
      if (BX_W > PAY_W)          $fatal(1, "framer: bunch count wider than payload");
      if (IDX_W + 1 + BW > PAY_W) $fatal(1, "framer: test word does not fit payload");
   end

   logic [DW-1:0]                 ch_in [NUM_CH];
   logic [DW-1:0]                 ch_al [NUM_CH];
   logic [NUM_CH-1:0][DSEL_W-1:0] dly_sel;
   logic                          test_en;
   logic                          clr_err;
   logic [NUM_PAT-1:0][BW-1:0]    pat;
   logic [BX_W-1:0]               bx_cnt;
   logic [IDX_W-1:0]              tst_idx;
   logic                          cap_mismatch;
   logic [PAY_W-1:0]              orbit_pay;
   logic [PAY_W-1:0]              test_pay;
   logic [WORD_W-1:0]             word_d;

   assign ch_in[0] = {ch0_cap, ch0_exp, ch0_mant};
   assign ch_in[1] = {ch1_cap, ch1_exp, ch1_mant};

   ddf_cfg_regs #(
      .ADDR_W (ADDR_W),
      .NUM_PAT(NUM_PAT),
      .NUM_CH (NUM_CH),
      .DSEL_W (DSEL_W)
   ) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cfg_we),
      .addr   (cfg_addr),
      .wdata  (cfg_wdata),
      .dly_sel(dly_sel),
      .test_en(test_en),
      .clr_err(clr_err),
      .pat    (pat)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         ddf_align_delay #(
            .W      (DW),
            .MAX_DLY(MAX_DLY),
            .SEL_W  (DSEL_W)
         ) u_dly (
            .clk  (clk),
            .rst_n(rst_n),
            .sel  (dly_sel[c]),
            .din  (ch_in[c]),
            .dout (ch_al[c])
         );
      end
   endgenerate

   ddf_orbit_ctrl #(
      .BX_W   (BX_W),
      .NUM_PAT(NUM_PAT),
      .IDX_W  (IDX_W)
   ) u_orbit (
      .clk    (clk),
      .rst_n  (rst_n),
      .bc0    (bc0),
      .test_en(test_en),
      .bx_cnt (bx_cnt),
      .tst_idx(tst_idx)
   );

   assign cap_mismatch = ch_al[0][DW-1 -: CAP_W] != ch_al[1][DW-1 -: CAP_W];

   always_comb begin
      orbit_pay              = '0;
      orbit_pay[BX_W-1:0]    = bx_cnt;
      test_pay               = '0;
      test_pay[IDX_W+BW:0]   = {tst_idx, 1'b0, pat[tst_idx]};
      if (bc0)          word_d = {WT_ORBIT, orbit_pay};
      else if (test_en) word_d = {WT_TEST, test_pay};
      else              word_d = {WT_DATA, ch_al[1][SMP_W-1:0], ch_al[0][SMP_W-1:0]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_word <= '0;
         dig_rst    <= 1'b0;
         sync_err   <= 1'b0;
      end else begin
         frame_word <= word_d;
         dig_rst    <= bc0;
         sync_err   <= cap_mismatch | (sync_err & ~clr_err);
      end
   end

   // R6: once raised, the flag stays up unless a clear is written
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_err && !clr_err) |=> sync_err);

   // R5: the digitizer reset always travels with an orbit word
   a_r5_rst_with_orbit: assert property (@(posedge clk) disable iff (!rst_n)
      dig_rst |-> frame_word[WORD_W-1 -: 2] == WT_ORBIT);

   // R9: a marker always produces an orbit word, whatever the mode
   a_r9_orbit_first: assert property (@(posedge clk) disable iff (!rst_n)
      bc0 |=> frame_word[WORD_W-1 -: 2] == WT_ORBIT);

   // R2: once out of reset the output never carries the idle type
   a_r2_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> frame_word[WORD_W-1 -: 2] != WT_IDLE);

endmodule

// File: tb/test_dual_digitizer_framer.sv
module test_dual_digitizer_framer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        b_bc0 = 1'b0;
   logic [1:0]  b_e0 = '0, b_e1 = '0, b_c0 = '0, b_c1 = '0;
   logic [4:0]  b_m0 = '0, b_m1 = '0;
   logic        b_we = 1'b0;
   logic [4:0]  b_addr = '0;
   logic [7:0]  b_wd = '0;
   logic [15:0] frame_word;
   logic        dig_rst;
   logic        sync_err;

   always #10 clk = ~clk;

   dual_digitizer_framer i_dual_digitizer_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bc0       (b_bc0),
      .ch0_exp   (b_e0),
      .ch0_mant  (b_m0),
      .ch0_cap   (b_c0),
      .ch1_exp   (b_e1),
      .ch1_mant  (b_m1),
      .ch1_cap   (b_c1),
      .cfg_we    (b_we),
      .cfg_addr  (b_addr),
      .cfg_wdata (b_wd),
      .frame_word(frame_word),
      .dig_rst   (dig_rst),
      .sync_err  (sync_err)
   );

   int total = 0;
   int bad   = 0;

   // reference state
   logic [1:0] m_d0 = '0, m_d1 = '0;
   bit         m_test = 1'b0;
   logic [7:0] m_pat [20];
   logic [8:0] m_sh0 [3];
   logic [8:0] m_sh1 [3];
   int         m_bx = 0;
   int         m_idx = 0;
   bit         m_err = 1'b0;
   string      tag_over = "";
   logic [1:0] cap_a = '0, cap_b = '0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
      end
   endtask

   function automatic logic [8:0] pick(input logic [1:0] d, input logic [8:0] cur, input logic [8:0] sh0,
                                       input logic [8:0] sh1, input logic [8:0] sh2);
      case (d)
         2'd0:    return cur;
         2'd1:    return sh0;
         2'd2:    return sh1;
         default: return sh2;
      endcase
   endfunction

   task automatic tick();
      logic [8:0]  cur0, cur1, al0, al1;
      logic [15:0] exp_word;
      bit          clr, exp_err;
      string       ftag;
      cur0 = {b_c0, b_e0, b_m0};
      cur1 = {b_c1, b_e1, b_m1};
      al0  = pick(m_d0, cur0, m_sh0[0], m_sh0[1], m_sh0[2]);
      al1  = pick(m_d1, cur1, m_sh1[0], m_sh1[1], m_sh1[2]);
      clr  = b_we && b_addr == 5'd0 && b_wd[5];
      if (b_bc0) begin
         exp_word = {2'b10, 2'b00, 12'(m_bx)};
         ftag = m_test ? "R9" : "R4";
      end else if (m_test) begin
         exp_word = {2'b11, 5'(m_idx), 1'b0, m_pat[m_idx]};
         ftag = "R8";
      end else begin
         exp_word = {2'b01, al1[6:0], al0[6:0]};
         ftag = (m_d0 == 0 && m_d1 == 0) ? "R2" : "R3";
      end
      if (tag_over != "") ftag = tag_over;
      exp_err = (al0[8:7] != al1[8:7]) || (m_err && !clr);
      m_sh0[2] = m_sh0[1]; m_sh0[1] = m_sh0[0]; m_sh0[0] = cur0;
      m_sh1[2] = m_sh1[1]; m_sh1[1] = m_sh1[0]; m_sh1[0] = cur1;
      if (b_bc0)       m_idx = 0;
      else if (m_test) m_idx = (m_idx == 19) ? 0 : m_idx + 1;
      m_bx = b_bc0 ? 0 : ((m_bx == 4095) ? 4095 : m_bx + 1);
      if (b_we) begin
         if (b_addr == 5'd0) begin
            m_d0 = b_wd[1:0]; m_d1 = b_wd[3:2]; m_test = b_wd[4];
         end else if (b_addr <= 5'd20) begin
            m_pat[int'(b_addr) - 1] = b_wd;
         end
      end
      m_err = exp_err;
      @(posedge clk); #2;
      chk(frame_word == exp_word, ftag, 32'(frame_word), 32'(exp_word));
      chk(dig_rst == b_bc0, "R5", 32'(dig_rst), 32'(b_bc0));
      chk(sync_err == exp_err, clr ? "R7" : "R6", 32'(sync_err), 32'(exp_err));
   endtask

   // digitizer models: fresh random samples, caps rotating and restarting on dig_rst
   task automatic drive(input bit glitch);
      b_e0 = 2'($urandom); b_m0 = 5'($urandom);
      b_e1 = 2'($urandom); b_m1 = 5'($urandom);
      b_c0 = cap_a;
      b_c1 = glitch ? cap_b + 2'd1 : cap_b;
   endtask

   task automatic step(input bit bc, input bit glitch);
      drive(glitch);
      b_bc0 = bc;
      tick();
      b_bc0 = 1'b0;
      b_we  = 1'b0;
      if (dig_rst) begin cap_a = '0; cap_b = '0; end
      else begin cap_a = cap_a + 2'd1; cap_b = cap_b + 2'd1; end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d, input bit bc);
      b_we = 1'b1; b_addr = a; b_wd = d;
      step(bc, 1'b0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog R4 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20021));
      for (int i = 0; i < 20; i++) m_pat[i] = '0;
      for (int i = 0; i < 3; i++) begin m_sh0[i] = '0; m_sh1[i] = '0; end

      // R1: reset state
      repeat (3) @(posedge clk);
      #2;
      chk(frame_word == 16'h0, "R1", 32'(frame_word), 32'h0);
      chk(dig_rst == 1'b0, "R1", 32'(dig_rst), 32'h0);
      chk(sync_err == 1'b0, "R1", 32'(sync_err), 32'h0);
      rst_n = 1'b1;

      // R2: plain sample words with zero delay
      repeat (8) step(1'b0, 1'b0);

      // R3: unequal delays, then every equal pairing
      wr(5'd0, 8'b0000_1100, 1'b0);
      repeat (10) step(1'b0, 1'b0);
      wr(5'd0, 8'b0000_0110, 1'b0);
      repeat (10) step(1'b0, 1'b0);
      for (int d = 0; d < 4; d++) begin
         wr(5'd0, 8'(d * 5) | 8'h20, 1'b0);
         repeat (6) step(1'b0, 1'b0);
      end

      // R4 and R5: orbit markers at known gaps, including back to back
      step(1'b1, 1'b0);
      repeat (9) step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      step(1'b1, 1'b0);
      repeat (4) step(1'b0, 1'b0);

      // R7: clear with no mismatch, then clear during a glitch (set wins)
      wr(5'd0, 8'h20, 1'b0);
      step(1'b0, 1'b1);
      repeat (2) step(1'b0, 1'b0);
      b_we = 1'b1; b_addr = 5'd0; b_wd = 8'h20;
      step(1'b0, 1'b1);
      wr(5'd0, 8'h20, 1'b0);
      repeat (2) step(1'b0, 1'b0);

      // R8: load patterns, then R10: unmapped writes must not disturb them
      for (int p = 1; p <= 20; p++) wr(5'(p), 8'(8'hA0 + p), 1'b0);
      for (int a = 21; a < 32; a++) wr(5'(a), 8'hFF, 1'b0);
      wr(5'd0, 8'h10, 1'b0);
      tag_over = "R10";
      repeat (20) step(1'b0, 1'b0);
      tag_over = "";
      repeat (27) step(1'b0, 1'b0);
      step(1'b1, 1'b0);                 // R9: orbit inside test mode
      repeat (6) step(1'b0, 1'b0);
      wr(5'd0, 8'h20, 1'b0);

      // random mix of samples, markers, writes and glitches
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = int'($urandom % 100);
         if (r < 3) begin
            logic [1:0] d0, d1;
            d0 = 2'($urandom);
            d1 = ($urandom % 5 == 0) ? 2'($urandom) : d0;
            wr(5'd0, {2'b00, ($urandom % 4 == 0), ($urandom % 6 == 0), d1, d0}, 1'b0);
         end else if (r < 5) begin
            wr(5'($urandom), 8'($urandom), 1'b0);
         end else begin
            step(($urandom % 40 == 0), ($urandom % 150 == 0));
         end
      end

      // R4: a gap longer than the counter range saturates the payload
      wr(5'd0, 8'h20, 1'b1);
      repeat (4200) step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      repeat (3) step(1'b0, 1'b0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule